// File: doc/BRIEF.md
# DS3 Frame-Slave Transmit Payload Stage

This block is the transmit payload entry point of a DS3 framer whose frame timing is dictated by the system side. A serial payload stream arrives one bit per rising edge of the 44.736 MHz transmit clock. The block keeps its own position within the 4760-bit M-frame: seven subframes, each of eight 85-bit blocks, where every block opens with one overhead slot followed by 84 payload slots. It merges the incoming payload with locally generated overhead bits into one registered serial output.

The system side is the frame master. It raises a one-clock reference pulse together with the first bit of every new frame, and the block restarts its count from that bit. One clock before each overhead slot the block raises an indicator, so the source can hold its next payload bit for one clock. The payload input is ignored during overhead slots. If a reference edge lands anywhere other than frame position zero, the counters realign to it and a sticky misalignment flag is set. The reference input must already be synchronous to the transmit clock.

Overhead values are as follows. The block supplies the framing and multiframe alignment patterns itself. The X, P and C values come from input ports, and parity is computed elsewhere.

Top module: `ds3s_tx_slave`

## Requirements
- R1: When the current slot is a payload slot, `ser_out` equals the `pay_in` value sampled at that rising edge, visible from the following clock onward (one clock of latency).
- R2: In an overhead slot the value on `pay_in` has no effect on `ser_out`. The overhead bit is sent instead.
- R3: `oh_ind` is high for exactly the one clock in which the current position is the last bit (bit 84) of a block, i.e. the clock just before an overhead slot, and low in every other clock.
- R4: A rising edge on `fref` (high now, low in the previous clock) makes the current clock frame position 0 (the X bit of subframe 1). Counting continues from that point.
- R5: Holding `fref` high for several clocks restarts the frame only on the rising edge. The following high clocks advance the count normally.
- R6: Without reference pulses the frame runs freely and wraps after 4760 bits to position 0.
- R7: `misalign` is set when a rising `fref` edge arrives while the position is not 0. A rising edge at position 0 does not set it. Once set, it stays set until reset.
- R8: Overhead bit values, with subframes s = 0..6 and blocks b = 0..7. For b = 0: `x_val` in s = 0,1; `p_val` in s = 2,3; and 0, 1, 0 in s = 4, 5, 6. For odd b = 1,3,5,7: the values 1, 0, 0, 1. For b = 2,4,6: `cbits[3*s + b/2 - 1]`.
- R9: While `rst` is high and right after it falls, `ser_out` is 1, `oh_ind` is 0 and `misalign` is 0. The first clock after reset processes frame position 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit bit clock |
| rst | input | 1 | Synchronous active-high reset |
| pay_in | input | 1 | Serial payload bit from the system side |
| fref | input | 1 | Frame reference pulse, high with the first bit of a frame |
| x_val | input | 1 | Value sent in the X overhead slots |
| p_val | input | 1 | Value sent in the P overhead slots |
| cbits | input | 21 | C-bit values, three per subframe, index 3*s + j |
| ser_out | output | 1 | Registered merged serial stream |
| oh_ind | output | 1 | Overhead warning, high one clock before each overhead slot |
| misalign | output | 1 | Sticky flag for a reference edge off frame position 0 |

## Verification
A pseudo-random payload run framed by correctly placed reference pulses checks the overhead values at every slot of whole frames, and also shows that a well-placed pulse leaves the flag clear. A run in which the payload always carries the complement of the due overhead bit, with the X, P and C values flipped, separates true overhead insertion from leakage of payload into overhead slots. Constant-one payload over more than two frames without any pulse exposes a wrong frame length or wrap point. A mid-frame pulse and a pulse held high for several clocks separate edge-based restart from level-based restart and confirm that the flag is sticky.

// File: rtl/ds3s_pkg.sv
package ds3s_pkg;

    localparam int BLK_BITS     = 85;
    localparam int BLKS_PER_SUB = 8;
    localparam int SUBS_PER_FRM = 7;
    localparam int C_PER_SUB    = 3;

    localparam int BIT_W      = $clog2(BLK_BITS);
    localparam int BLK_W      = $clog2(BLKS_PER_SUB);
    localparam int SUB_W      = $clog2(SUBS_PER_FRM);
    localparam int CB_W       = SUBS_PER_FRM * C_PER_SUB;
    localparam int FRAME_BITS = BLK_BITS * BLKS_PER_SUB * SUBS_PER_FRM;

    typedef struct packed {
        logic [SUB_W-1:0] sub;
        logic [BLK_W-1:0] blk;
        logic [BIT_W-1:0] bpos;
    } fpos_t;

    typedef enum logic [1:0] {
        OH_XPM = 2'd0,
        OH_F   = 2'd1,
        OH_C   = 2'd2
    } oh_kind_e;

    function automatic oh_kind_e kind_of(input logic [BLK_W-1:0] blk);
        if (blk == '0)  return OH_XPM;
        if (blk[0])     return OH_F;
        return OH_C;
    endfunction

    // framing pattern across odd blocks: 1,0,0,1
    function automatic logic f_bit(input logic [BLK_W-1:0] blk);
        logic [BLK_W-2:0] k;
        k = blk[BLK_W-1:1];
        return (k == '0) || (k == '1);
    endfunction

    // multiframe alignment bits in subframes 5..7 (0-based 4..6): 0,1,0
    function automatic logic m_bit(input logic [SUB_W-1:0] sub);
        return sub == SUB_W'(5);
    endfunction

endpackage

// File: rtl/ds3s_frame_ctr.sv
module ds3s_frame_ctr
    import ds3s_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  fref,
    output fpos_t cur,
    output fpos_t eff,
    output logic  rise,
    output logic  misalign
);

    logic  fref_q;
    fpos_t nxt;

    assign rise = fref & ~fref_q;
    assign eff  = rise ? '0 : cur;

    always_comb begin
        nxt = eff;
        if (eff.bpos == BIT_W'(BLK_BITS - 1)) begin
            nxt.bpos = '0;
            if (eff.blk == BLK_W'(BLKS_PER_SUB - 1)) begin
                nxt.blk = '0;
                nxt.sub = (eff.sub == SUB_W'(SUBS_PER_FRM - 1)) ? '0
                                                                 : eff.sub + SUB_W'(1);
            end else begin
                nxt.blk = eff.blk + BLK_W'(1);
            end
        end else begin
            nxt.bpos = eff.bpos + BIT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur      <= '0;
            fref_q   <= 1'b0;
            misalign <= 1'b0;
        end else begin
            cur      <= nxt;
            fref_q   <= fref;
            misalign <= misalign | (rise && (cur != '0));
        end
    end

    p_pos_range_r6: assert property (@(posedge clk) disable iff (rst)
        (int'(cur.bpos) < BLK_BITS) && (int'(cur.blk) < BLKS_PER_SUB) &&
        (int'(cur.sub) < SUBS_PER_FRM));

    p_restart_r4: assert property (@(posedge clk) disable iff (rst)
        (fref && !$past(fref)) |=> (cur.sub == '0 && cur.blk == '0 && cur.bpos == BIT_W'(1)));

    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        misalign |=> misalign);

endmodule

// File: rtl/ds3s_oh_gen.sv
module ds3s_oh_gen
    import ds3s_pkg::*;
(
    input  fpos_t           pos,
    input  logic            x_val,
    input  logic            p_val,
    input  logic [CB_W-1:0] cbits,
    output logic            oh_val
);

    localparam int IDX_W = $clog2(CB_W);

    logic [IDX_W-1:0] cidx;
    logic             cbit;
    logic             xpm;

    assign cidx = IDX_W'(int'(pos.sub) * C_PER_SUB + int'(pos.blk >> 1) - 1);
    assign cbit = (int'(cidx) < CB_W) ? cbits[cidx] : 1'b0;

    always_comb begin
        if (int'(pos.sub) < 2)      xpm = x_val;
        else if (int'(pos.sub) < 4) xpm = p_val;
        else                        xpm = m_bit(pos.sub);
    end

    always_comb begin
        unique case (kind_of(pos.blk))
            OH_XPM:  oh_val = xpm;
            OH_F:    oh_val = f_bit(pos.blk);
            default: oh_val = cbit;
        endcase
    end

endmodule

// File: rtl/ds3s_tx_slave.sv
module ds3s_tx_slave
    import ds3s_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            pay_in,
    input  logic            fref,
    input  logic            x_val,
    input  logic            p_val,
    input  logic [CB_W-1:0] cbits,
    output logic            ser_out,
    output logic            oh_ind,
    output logic            misalign
);

    fpos_t cur;
    fpos_t eff;
    logic  rise;
    logic  oh_val;
    logic  oh_slot;

    ds3s_frame_ctr u_ctr (
        .clk      (clk),
        .rst      (rst),
        .fref     (fref),
        .cur      (cur),
        .eff      (eff),
        .rise     (rise),
        .misalign (misalign)
    );

    ds3s_oh_gen u_oh (
        .pos    (eff),
        .x_val  (x_val),
        .p_val  (p_val),
        .cbits  (cbits),
        .oh_val (oh_val)
    );

    assign oh_slot = (eff.bpos == '0);
    assign oh_ind  = (cur.bpos == BIT_W'(BLK_BITS - 1));

    always_ff @(posedge clk) begin
        if (rst) ser_out <= 1'b1;
        else     ser_out <= oh_slot ? oh_val : pay_in;
    end

    p_payload_pass_r1: assert property (@(posedge clk) disable iff (rst)
        !oh_slot |=> (ser_out == $past(pay_in)));

    p_oh_insert_r2: assert property (@(posedge clk) disable iff (rst)
        oh_slot |=> (ser_out == $past(oh_val)));

    p_ohind_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        oh_ind |=> !oh_ind);

    p_ohind_warns_r3: assert property (@(posedge clk) disable iff (rst)
        oh_ind |=> oh_slot);

endmodule

// File: tb/ds3s_tx_slave_tb.sv
`timescale 1ns/1ps
module ds3s_tx_slave_tb_top;

    localparam int NFR = 4760;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pay_in = 1'b0;
    logic        fref = 1'b0;
    logic        x_val = 1'b1;
    logic        p_val = 1'b0;
    logic [20:0] cbits = '0;
    logic        ser_out;
    logic        oh_ind;
    logic        misalign;

    int n_chk = 0;
    int n_fail = 0;

    // bench frame model
    int   msub, mblk, mbit;
    logic mfq, mmis;
    logic [15:0] lfsr = 16'hACE1;
    int   pmode = 0;
    string tag_ovr = "";

    always #10 clk = ~clk;

    ds3s_tx_slave dut_i (
        .clk(clk), .rst(rst), .pay_in(pay_in), .fref(fref),
        .x_val(x_val), .p_val(p_val), .cbits(cbits),
        .ser_out(ser_out), .oh_ind(oh_ind), .misalign(misalign)
    );

    task automatic chk(input logic ok, input string req, input logic act, input logic exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at t=%0t: actual %b expected %b (pos s%0d b%0d k%0d)",
                     req, $time, act, exp, msub, mblk, mbit);
        end
    endtask

    function automatic logic exp_oh(input int s, input int b);
        if (b == 0) begin
            if (s < 2) return x_val;
            if (s < 4) return p_val;
            return (s == 5);
        end
        if (b % 2 == 1) return (b == 1 || b == 7);
        return cbits[s*3 + b/2 - 1];
    endfunction

    function automatic logic next_pay();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (pmode)
            1: return 1'b0;
            2: return 1'b1;
            3: return (mbit == 0) ? ~exp_oh(msub, mblk) : lfsr[0];
            default: return lfsr[0];
        endcase
    endfunction

    // called at a negedge; returns at the next negedge
    task automatic step(input logic fr);
        logic  p, rs, e;
        string t;
        p = next_pay();
        pay_in = p;
        fref   = fr;
        #1;
        chk(oh_ind === (mbit == 84), "R3", oh_ind, (mbit == 84));
        rs = fr && !mfq;
        if (rs) begin
            if (msub != 0 || mblk != 0 || mbit != 0) mmis = 1'b1;
            msub = 0; mblk = 0; mbit = 0;
        end
        if (mbit == 0) begin
            e = exp_oh(msub, mblk);
            t = rs ? "R4" : "R8";
        end else begin
            e = p;
            t = "R1";
        end
        if (tag_ovr != "") t = tag_ovr;
        mbit++;
        if (mbit == 85) begin
            mbit = 0; mblk++;
            if (mblk == 8) begin mblk = 0; msub = (msub + 1) % 7; end
        end
        mfq = fr;
        @(posedge clk);
        @(negedge clk);
        chk(ser_out === e, t, ser_out, e);
        chk(misalign === mmis, "R7", misalign, mmis);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; fref = 1'b0;
        repeat (3) @(negedge clk);
        chk(ser_out === 1'b1, "R9", ser_out, 1'b1);
        chk(oh_ind === 1'b0, "R9", oh_ind, 1'b0);
        chk(misalign === 1'b0, "R9", misalign, 1'b0);
        rst = 1'b0;
        msub = 0; mblk = 0; mbit = 0; mfq = 1'b0; mmis = 1'b0;
        #1;
        chk(ser_out === 1'b1, "R9", ser_out, 1'b1);
        chk(oh_ind === 1'b0, "R9", oh_ind, 1'b0);
        chk(misalign === 1'b0, "R9", misalign, 1'b0);
        @(negedge clk);
        // the first clock after reset processes position 0 (X bit, x_val)
        chk(ser_out === x_val, "R9", ser_out, x_val);
        msub = 0; mblk = 0; mbit = 1;
    endtask

    task automatic t_aligned();
        tag_ovr = ""; pmode = 0;
        x_val = 1'b1; p_val = 1'b0; cbits = 21'h0A5C3;
        do_reset();
        while (mbit != 0 || mblk != 0 || msub != 0) step(1'b0);
        step(1'b1);
        for (int i = 1; i < NFR; i++) step(1'b0);
        step(1'b1);   // aligned pulse: R7 flag must stay clear
        for (int i = 0; i < 300; i++) step(1'b0);
    endtask

    task automatic t_ohslot_ignored();
        tag_ovr = "R2"; pmode = 3;
        x_val = 1'b0; p_val = 1'b1; cbits = ~21'h0A5C3;
        do_reset();
        for (int i = 0; i < NFR + 10; i++) step(1'b0);
        tag_ovr = "";
    endtask

    task automatic t_freerun();
        tag_ovr = "R6"; pmode = 2;
        x_val = 1'b0; p_val = 1'b0; cbits = '0;
        do_reset();
        for (int i = 0; i < 2*NFR + 20; i++) step(1'b0);
        tag_ovr = "";
    endtask

    task automatic t_misaligned();
        tag_ovr = ""; pmode = 0;
        x_val = 1'b1; p_val = 1'b1; cbits = 21'h1F00F;
        do_reset();
        for (int i = 0; i < 1000; i++) step(1'b0);
        step(1'b1);   // off-position edge: restart, flag set
        for (int i = 0; i < 400; i++) step(1'b0);
        step(1'b1);
        for (int i = 0; i < 200; i++) step(1'b0);
        chk(misalign === 1'b1, "R7", misalign, 1'b1);
    endtask

    task automatic t_fref_held();
        tag_ovr = ""; pmode = 0;
        x_val = 1'b1; p_val = 1'b0; cbits = 21'h12345;
        do_reset();
        for (int i = 0; i < 300; i++) step(1'b0);
        step(1'b1);
        tag_ovr = "R5";
        for (int i = 0; i < 6; i++) step(1'b1);
        tag_ovr = "";
        for (int i = 0; i < 200; i++) step(1'b0);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_aligned();
        t_ohslot_ignored();
        t_freerun();
        t_misaligned();
        t_fref_held();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule